// File: doc/BRIEF.md
# Command Activation Write Trigger

This block sits between the host register write path and a per-slot command launcher. Each command slot owns a 64-bit activation register made of two 32-bit halves, and the host writes it with 32-bit or 64-bit accesses. The block works out when a write has supplied a complete 64-bit command pointer. At that point it emits a one-cycle start pulse that carries the slot index and the assembled pointer. It also keeps one shared 32-bit upper-address holding register, which the host can write and read at its own address.

A mode input comes from port control. When the mode is set, a 32-bit write to the lower half of a slot is enough to launch the command, and the holding register supplies the upper 32 bits. This suits hosts whose memory lies below 4 GiB. When the mode is clear, a lower-half write only stores its data, and a later upper-half write launches the command with that stored half. A single 64-bit write launches in either mode. A flush request or a reset discards every stored lower half.

Top module: `cmdActTrigger`

## Requirements
- R1: After reset, startValid is 0 and the holding register reads back as zero.
- R2: A write of either size to HOLD_ADDR (default 0x0F0) stores wrData[31:0] in the holding register. rdData returns that value while rdAddr equals HOLD_ADDR and returns zero at any other rdAddr.
- R3: With act32Mode=1, a 32-bit write (wrSize=0) to a slot's lower half (offset +0) raises startValid in the next cycle. The start carries the pointer {holding register, wrData[31:0]}.
- R4: With act32Mode=0, a 32-bit write to a lower half raises no start. It stores wrData[31:0] for that slot.
- R5: In either mode, a 32-bit write to a slot's upper half (offset +4) raises startValid in the next cycle. The start carries the pointer {wrData[31:0], stored lower half of that slot}.
- R6: In either mode, a 64-bit write (wrSize=1) at a slot's lower-half offset starts that slot with pointer wrData[63:0]. A 64-bit write at an upper-half offset is ignored.
- R7: Slot registers sit at ACT_BASE + 8*slot (default ACT_BASE 0x100, 8 slots). startSlot equals (wrAddr-ACT_BASE)>>3. A write outside the slot region, or at an address that is not 4-byte aligned, causes no start and changes no stored half.
- R8: flushReq discards every stored lower half, so each reads as zero. Every write presented in the same cycle as flushReq is dropped.
- R9: Any start leaves the stored lower half of the started slot at zero.
- R10: startValid is high for exactly one cycle per accepted launching write, in the cycle after that write. It is low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high port reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 12 | Byte address of the write |
| wrData | input | 64 | Write data; 32-bit writes use bits [31:0] |
| wrSize | input | 1 | 0 = 32-bit write, 1 = 64-bit write |
| act32Mode | input | 1 | Lower-half write launches, using the holding register |
| flushReq | input | 1 | Discard stored lower halves |
| rdAddr | input | 12 | Read address for the holding register |
| rdData | output | 32 | Holding register readback, or zero |
| startValid | output | 1 | One-cycle launch pulse |
| startSlot | output | 3 | Slot index of the launch |
| startPtr | output | 64 | Assembled 64-bit command pointer |

## Verification
The bench mixes directed sequences with about 400 seeded random operations. The random operations cover slot, half, write size, mode, flush and address validity. Lower-half then upper-half pairs in the clear mode separate the stored-half path from the holding-register path. Lower-half writes with the mode set show whether the holding register, and not a stale stored half, fills the upper bits. Flushes, including those that collide with a write, and upper writes issued straight after a launch show whether stored halves are actually discarded. Misaligned addresses, out-of-region addresses and 64-bit upper-offset writes confirm that these writes launch nothing.

// File: rtl/cmdActPkg.sv
package cmdActPkg;
  // strobes from decode to datapath
  typedef struct packed {
    logic holdWr;     // load holding register
    logic lowStore;   // store lower half, no launch
    logic launchFull; // 64-bit write launches
    logic launchLow;  // lower half + holding register launches
    logic launchHigh; // upper half + stored lower half launches
    logic clearAll;   // discard stored lower halves
  } actStrobes_t;

  typedef enum logic {SZ_32 = 1'b0, SZ_64 = 1'b1} wrSize_e;
endpackage

// File: rtl/cmdActCtrl.sv
module cmdActCtrl
  import cmdActPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 8,
  parameter int ACT_BASE  = 'h100,
  parameter int HOLD_ADDR = 'h0F0,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int REGION_B = NUM_SLOTS * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrSize,
  input  logic              act32Mode,
  input  logic              flushReq,
  output actStrobes_t       strobes,
  output logic [SLOT_W-1:0] wrSlot
);
  logic [ADDR_W-1:0] offs;
  logic inRegion, aligned, isHigh, actHit, holdHit, wrOk, is64;

  always_comb begin
    offs     = wrAddr - ADDR_W'(ACT_BASE);
    inRegion = (wrAddr >= ADDR_W'(ACT_BASE)) && (offs < ADDR_W'(REGION_B));
    aligned  = (offs[1:0] == 2'b00);
    isHigh   = offs[2];
    wrSlot   = offs[SLOT_W+2:3];
    wrOk     = wrEn && !flushReq;
    actHit   = wrOk && inRegion && aligned;
    holdHit  = wrOk && (wrAddr == ADDR_W'(HOLD_ADDR));
    is64     = (wrSize_e'(wrSize) == SZ_64);

    strobes            = '0;
    strobes.clearAll   = flushReq;
    strobes.holdWr     = holdHit;
    strobes.launchFull = actHit && !isHigh && is64;
    strobes.launchLow  = actHit && !isHigh && !is64 && act32Mode;
    strobes.lowStore   = actHit && !isHigh && !is64 && !act32Mode;
    strobes.launchHigh = actHit && isHigh && !is64;
  end

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.holdWr, strobes.lowStore, strobes.launchFull,
              strobes.launchLow, strobes.launchHigh}));

  // R4
  store_only_clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.lowStore |-> !act32Mode);

  // R8
  flush_blocks_writes_chk: assert property (@(posedge clk) disable iff (rst)
    flushReq |-> !(strobes.lowStore || strobes.launchFull || strobes.launchLow
                   || strobes.launchHigh || strobes.holdWr));
endmodule

// File: rtl/cmdActData.sv
module cmdActData
  import cmdActPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 8,
  parameter int HOLD_ADDR = 'h0F0,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  actStrobes_t       strobes,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [63:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              startValid,
  output logic [SLOT_W-1:0] startSlot,
  output logic [63:0]       startPtr
);
  logic [31:0] holdReg;
  logic [31:0] lowMem [NUM_SLOTS];
  logic        anyLaunch;
  logic [63:0] nextPtr;

  always_comb begin
    anyLaunch = strobes.launchFull || strobes.launchLow || strobes.launchHigh;
    if (strobes.launchFull)     nextPtr = wrData;
    else if (strobes.launchLow) nextPtr = {holdReg, wrData[31:0]};
    else                        nextPtr = {wrData[31:0], lowMem[wrSlot]};
    rdData = (rdAddr == ADDR_W'(HOLD_ADDR)) ? holdReg : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) holdReg <= '0;
    else if (strobes.holdWr) holdReg <= wrData[31:0];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_low
    always_ff @(posedge clk) begin
      if (rst || strobes.clearAll) lowMem[s] <= '0;
      else if (wrSlot == SLOT_W'(s)) begin
        if (strobes.lowStore) lowMem[s] <= wrData[31:0];
        else if (anyLaunch)   lowMem[s] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startValid <= 1'b0;
      startSlot  <= '0;
      startPtr   <= '0;
    end else begin
      startValid <= anyLaunch;
      if (anyLaunch) begin
        startSlot <= wrSlot;
        startPtr  <= nextPtr;
      end
    end
  end

  // R4
  low_store_kept_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.lowStore |=> !startValid && lowMem[$past(wrSlot)] == $past(wrData[31:0]));

  // R5
  high_uses_stored_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.launchHigh |=> startValid && startPtr[31:0] == $past(lowMem[wrSlot]));

  // R9
  start_consumes_low_chk: assert property (@(posedge clk) disable iff (rst)
    anyLaunch |=> lowMem[$past(wrSlot)] == 32'h0);

  // R8
  flush_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAll |=> !startValid);

  // R3
  low_launch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.launchLow |=> startValid && startPtr[63:32] == $past(holdReg));
endmodule

// File: rtl/cmdActTrigger.sv
module cmdActTrigger
  import cmdActPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 8,
  parameter int ACT_BASE  = 'h100,
  parameter int HOLD_ADDR = 'h0F0,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [63:0]       wrData,
  input  logic              wrSize,
  input  logic              act32Mode,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              startValid,
  output logic [SLOT_W-1:0] startSlot,
  output logic [63:0]       startPtr
);
  actStrobes_t       strobes;
  logic [SLOT_W-1:0] wrSlot;

  cmdActCtrl #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .ACT_BASE(ACT_BASE),
               .HOLD_ADDR(HOLD_ADDR)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .act32Mode(act32Mode), .flushReq(flushReq), .strobes(strobes), .wrSlot(wrSlot));

  cmdActData #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .HOLD_ADDR(HOLD_ADDR)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .wrSlot(wrSlot), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .startValid(startValid),
    .startSlot(startSlot), .startPtr(startPtr));

  // R10
  pulse_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    startValid |-> $past(wrEn) && !$past(flushReq));
endmodule

// File: tb/tb_cmdActTrigger.sv
module tb_cmdActTrigger;
  localparam int HOLD = 'h0F0;
  localparam int BASE = 'h100;

  logic clk = 0, rst = 1, wrEn = 0, wrSize = 0, act32Mode = 0, flushReq = 0;
  logic [11:0] wrAddr = '0, rdAddr = 12'(HOLD);
  logic [63:0] wrData = '0;
  logic [31:0] rdData;
  logic startValid;
  logic [2:0] startSlot;
  logic [63:0] startPtr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] mLow [8];
  logic [31:0] mHold;

  cmdActTrigger dut (.clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrSize(wrSize), .act32Mode(act32Mode), .flushReq(flushReq), .rdAddr(rdAddr),
    .rdData(rdData), .startValid(startValid), .startSlot(startSlot), .startPtr(startPtr));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reference model: returns expected launch
  task automatic predict(input logic [11:0] a, input logic [63:0] d, input logic sz,
                         input logic m, input logic fl, output logic v,
                         output logic [2:0] s, output logic [63:0] p, output string tag);
    int off;
    v = 0; s = 0; p = 0; tag = "R7";
    off = int'(a) - BASE;
    if (fl) begin
      for (int i = 0; i < 8; i++) mLow[i] = 0;
      tag = "R8";
    end else if (int'(a) == HOLD) begin
      mHold = d[31:0]; tag = "R2";
    end else if (off >= 0 && off < 64 && off % 4 == 0) begin
      s = 3'(off / 8);
      if (off % 8 == 0 && sz) begin
        v = 1; p = d; mLow[s] = 0; tag = "R6";
      end else if (off % 8 == 0 && m) begin
        v = 1; p = {mHold, d[31:0]}; mLow[s] = 0; tag = "R3";
      end else if (off % 8 == 0) begin
        mLow[s] = d[31:0]; tag = "R4";
      end else if (!sz) begin
        v = 1; p = {d[31:0], mLow[s]}; mLow[s] = 0; tag = "R5";
      end else tag = "R6";
    end
  endtask

  task automatic doOp(input logic [11:0] a, input logic [63:0] d, input logic sz,
                      input logic m, input logic fl);
    logic ev; logic [2:0] es; logic [63:0] ep; string tag;
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d; wrSize = sz; act32Mode = m; flushReq = fl;
    predict(a, d, sz, m, fl, ev, es, ep, tag);
    @(negedge clk);
    wrEn = 0; flushReq = 0;
    chk({tag, "/R10 valid"}, 64'(startValid), 64'(ev));
    if (ev) begin
      chk({tag, "/R7 slot"}, 64'(startSlot), 64'(es));
      chk({tag, " ptr"}, startPtr, ep);
    end
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk("R10 single pulse", 64'(startValid), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mLow[i] = 0;
    mHold = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 valid", 64'(startValid), 64'd0);
    chk("R1 hold", 64'(rdData), 64'd0);
    // R2 hold write/read
    doOp(12'(HOLD), 64'hFFFF_0000_ABCD_1234, 0, 0, 0);
    chk("R2 read", 64'(rdData), 64'(mHold));
    rdAddr = 12'h0F4; #1;
    chk("R2 other addr", 64'(rdData), 64'd0);
    rdAddr = 12'(HOLD);
    // R3 mode on low launch
    doOp(12'(BASE + 8*2), 64'h0000_0000_1111_2220, 0, 1, 0);
    idleCheck();
    // R4 then R5
    doOp(12'(BASE + 8*5), 64'h0000_0000_5555_0000, 0, 0, 0);
    doOp(12'(BASE + 8*5 + 4), 64'h0000_0000_0000_0007, 0, 0, 0);
    // R9 second upper write sees zero low
    doOp(12'(BASE + 8*5 + 4), 64'h0000_0000_0000_0008, 0, 1, 0);
    // R6 both modes, upper offset ignored
    doOp(12'(BASE + 8*7), 64'h1234_5678_9ABC_DEF0, 1, 0, 0);
    doOp(12'(BASE), 64'h0FED_CBA9_8765_4320, 1, 1, 0);
    doOp(12'(BASE + 8*3 + 4), 64'hAAAA_BBBB_CCCC_DDDD, 1, 0, 0);
    // R7 misaligned and out of region
    doOp(12'(BASE + 8*1 + 1), 64'h77, 0, 1, 0);
    doOp(12'(BASE + 64), 64'h88, 0, 1, 0);
    doOp(12'(BASE - 8), 64'h99, 1, 1, 0);
    // R8 store, flush with colliding write, then upper write
    doOp(12'(BASE + 8*4), 64'hDEAD_BEEF, 0, 0, 0);
    doOp(12'(BASE + 8*4 + 4), 64'h4444, 0, 0, 1);
    doOp(12'(BASE + 8*4 + 4), 64'h4444, 0, 0, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a; logic [63:0] d; int r;
      r = int'($urandom % 16);
      d = {$urandom, $urandom};
      if (r == 0) a = 12'(HOLD);
      else if (r == 1) a = 12'(BASE + ($urandom % 64) | 1);
      else if (r == 2) a = 12'(BASE + 64 + ($urandom % 32) * 4);
      else a = 12'(BASE + ($urandom % 8) * 8 + ($urandom % 2) * 4);
      doOp(a, d, 1'($urandom % 4 == 0), 1'($urandom % 2), 1'($urandom % 12 == 0));
      if (n % 25 == 0) chk("R2 random read", 64'(rdData), 64'(mHold));
    end
    finishRun();
  end
endmodule